// File: doc/BRIEF.md
# Transmit Preamble and Sync Framer

This block sits in front of a binary FSK modulator and wraps a stream of already-coded packet bytes into a complete over-the-air frame. It emits one symbol on each symbol-clock enable. A frame starts with a run of power ramp-up symbols, then an alternating preamble, then a 16-symbol sync word, then the packet bits, and ends with a run of power ramp-down symbols. A power-amplifier enable stays high for every symbol period of the frame.

At a start pulse the framer reads the channel descriptor byte, a sync class bit, a requested preamble length and the two ramp lengths. It latches them, so they may change while a frame is in flight. The rate field of the descriptor sets the allowed preamble range, and the coding field together with the sync class selects the sync word. A descriptor whose rate field is reserved is refused. The framer then raises a one-cycle error pulse and stays idle.

Packet bytes are pulled from the source with a ready/valid pair. The end-of-packet marker on the final byte closes the data phase.

Top module: `fsk_tx_framer`

## Requirements
- R1: `pa_en` goes high on the first symbol enable of a frame and stays high until the symbol enable that follows the last ramp-down symbol. Only the symbols emitted while it is high form the frame. They come in this order: ramp-up, preamble, sync word, packet data, ramp-down.
- R2: Preamble symbols alternate, and the first one is 1.
- R3: On a low-rate channel (descriptor bits 5:4 equal 1), the preamble length is the requested length clamped to 32..64. A request of 0 therefore gives 32.
- R4: On a high-rate channel (descriptor bits 5:4 equal 2), the preamble length is the requested length clamped to 48..128.
- R5: The sync word is sent MSB first. It is chosen by the sync class and the FEC flag, where the FEC flag is set only when descriptor bits 7:6 equal 2. Class 0 gives 0xE6D0 without FEC and 0xF498 with FEC. Class 1 gives 0x0B67 without FEC and 0x192F with FEC.
- R6: Data bytes are sent MSB first, one bit per symbol. A byte is taken when `in_ready` and `in_valid` are both high. The byte flagged `in_last` is the final one. If no byte is offered when one is needed, the data phase ends at that point, so a frame may carry no data at all.
- R7: Ramp-up and ramp-down are runs of 0 symbols. Each length is the requested value clamped to at most 32, and a length of 0 omits that phase.
- R8: A start pulse with descriptor bits 5:4 equal to 0 or 3 gives a single-cycle `err` in the next cycle. The framer does not become busy and does not enable the amplifier.
- R9: A start pulse while a frame is in progress has no effect on that frame and raises no error.
- R10: After reset, `sym_out`, `pa_en`, `busy`, `err` and `in_ready` are all 0.
- R11: `sym_out` and `pa_en` change only in the cycle after a symbol enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_en | input | 1 | Symbol-clock enable, one cycle per symbol |
| start | input | 1 | Begin a frame with the present configuration |
| chan_id | input | 8 | Channel descriptor: coding [7:6], rate [5:4], frequency [3:0] |
| sync_class | input | 1 | Sync word class |
| pre_len | input | 8 | Requested preamble length in symbols |
| ramp_up_len | input | 6 | Requested ramp-up length in symbols |
| ramp_dn_len | input | 6 | Requested ramp-down length in symbols |
| in_byte | input | 8 | Packet byte |
| in_valid | input | 1 | Packet byte is offered |
| in_last | input | 1 | Offered byte ends the packet |
| in_ready | output | 1 | Framer takes the offered byte this cycle |
| sym_out | output | 1 | Current symbol |
| pa_en | output | 1 | Amplifier enable for the frame |
| busy | output | 1 | A frame is in progress |
| err | output | 1 | Refused-start pulse |

## Verification
A wrong phase or count register shows up at once in the captured symbol string. A preamble that is one symbol too long or too short shifts the sync word and every later bit, and the mismatch appears within the same frame. A wrongly decoded descriptor shows up in the first sync symbol that differs from the selected word, and a wrong clamp limit changes the frame length. Handshake faults show up as a byte count that differs from the packet length once the frame ends, and a hold fault shows up as an output change in a cycle without a symbol enable.

// File: rtl/fsk_frm_pkg.sv
package fsk_frm_pkg;

    localparam int SYNC_W = 16;
    localparam logic [1:0] RATE_LO  = 2'd1;
    localparam logic [1:0] RATE_HI  = 2'd2;
    localparam logic [1:0] CODE_FEC = 2'd2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_UP,
        PH_PRE,
        PH_SYNC,
        PH_DATA,
        PH_DN
    } phase_e;

    function automatic logic [SYNC_W-1:0] pick_sync(input logic cls, input logic fec);
        case ({cls, fec})
            2'b00:   return 16'hE6D0;
            2'b01:   return 16'hF498;
            2'b10:   return 16'h0B67;
            default: return 16'h192F;
        endcase
    endfunction

endpackage

// File: rtl/fsk_frm_clamp.sv
module fsk_frm_clamp #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic [W-1:0] res
);
    always_comb begin
        if (val < lo)      res = lo;
        else if (val > hi) res = hi;
        else               res = val;
    end
endmodule

// File: rtl/fsk_frm_cfg.sv
module fsk_frm_cfg
    import fsk_frm_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int RAMP_W   = 6,
    parameter int RAMP_MAX = 32,
    parameter int LO_MIN   = 32,
    parameter int LO_MAX   = 64,
    parameter int HI_MIN   = 48,
    parameter int HI_MAX   = 128
) (
    input  logic [7:0]        chan_id,
    input  logic              sync_class,
    input  logic [CNT_W-1:0]  pre_len,
    input  logic [RAMP_W-1:0] up_len,
    input  logic [RAMP_W-1:0] dn_len,
    output logic              mod_bad,
    output logic [SYNC_W-1:0] sync_word,
    output logic [CNT_W-1:0]  pre_n,
    output logic [CNT_W-1:0]  up_n,
    output logic [CNT_W-1:0]  dn_n
);
    localparam int NRAMP = 2;

    logic [1:0]       rate_f;
    logic [1:0]       code_f;
    logic             hi_rate;
    logic [CNT_W-1:0] pre_lo;
    logic [CNT_W-1:0] pre_hi;

    assign rate_f    = chan_id[5:4];
    assign code_f    = chan_id[7:6];
    assign hi_rate   = (rate_f == RATE_HI);
    assign mod_bad   = !((rate_f == RATE_LO) || hi_rate);
    assign sync_word = pick_sync(sync_class, code_f == CODE_FEC);
    assign pre_lo    = hi_rate ? CNT_W'(HI_MIN) : CNT_W'(LO_MIN);
    assign pre_hi    = hi_rate ? CNT_W'(HI_MAX) : CNT_W'(LO_MAX);

    fsk_frm_clamp #(.W(CNT_W)) u_pre (
        .val(pre_len), .lo(pre_lo), .hi(pre_hi), .res(pre_n)
    );

    logic [RAMP_W-1:0] ramp_in  [NRAMP];
    logic [RAMP_W-1:0] ramp_out [NRAMP];

    assign ramp_in[0] = up_len;
    assign ramp_in[1] = dn_len;

    for (genvar g = 0; g < NRAMP; g++) begin : g_ramp
        fsk_frm_clamp #(.W(RAMP_W)) u_ramp (
            .val(ramp_in[g]),
            .lo('0),
            .hi(RAMP_W'(RAMP_MAX)),
            .res(ramp_out[g])
        );
    end

    assign up_n = {{(CNT_W-RAMP_W){1'b0}}, ramp_out[0]};
    assign dn_n = {{(CNT_W-RAMP_W){1'b0}}, ramp_out[1]};
endmodule

// File: rtl/fsk_tx_framer.sv
module fsk_tx_framer
    import fsk_frm_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int RAMP_W   = 6,
    parameter int BYTE_W   = 8,
    parameter int RAMP_MAX = 32,
    parameter int LO_MIN   = 32,
    parameter int LO_MAX   = 64,
    parameter int HI_MIN   = 48,
    parameter int HI_MAX   = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_en,
    input  logic              start,
    input  logic [7:0]        chan_id,
    input  logic              sync_class,
    input  logic [CNT_W-1:0]  pre_len,
    input  logic [RAMP_W-1:0] ramp_up_len,
    input  logic [RAMP_W-1:0] ramp_dn_len,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic              sym_out,
    output logic              pa_en,
    output logic              busy,
    output logic              err
);
    localparam int SYNC_IW = $clog2(SYNC_W);
    localparam int BIT_W   = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0]   ONE       = CNT_W'(1);
    localparam logic [CNT_W-1:0]   SYNC_LAST = CNT_W'(SYNC_W - 1);
    localparam logic [SYNC_IW-1:0] SYNC_TOP  = SYNC_IW'(SYNC_W - 1);
    localparam logic [BIT_W-1:0]   BYTE_TOP  = BIT_W'(BYTE_W - 1);

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  pre_n;
        logic [CNT_W-1:0]  up_n;
        logic [CNT_W-1:0]  dn_n;
        logic [SYNC_W-1:0] sync;
        logic [BYTE_W-1:0] shreg;
        logic              last;
        logic              sym;
        logic              pa;
        logic              err;
    } st_t;

    st_t s_d, s_q;

    logic              mod_bad;
    logic [SYNC_W-1:0] cfg_sync;
    logic [CNT_W-1:0]  cfg_pre;
    logic [CNT_W-1:0]  cfg_up;
    logic [CNT_W-1:0]  cfg_dn;
    logic              rdy;
    logic              go_tail;

    fsk_frm_cfg #(
        .CNT_W(CNT_W), .RAMP_W(RAMP_W), .RAMP_MAX(RAMP_MAX),
        .LO_MIN(LO_MIN), .LO_MAX(LO_MAX), .HI_MIN(HI_MIN), .HI_MAX(HI_MAX)
    ) u_cfg (
        .chan_id   (chan_id),
        .sync_class(sync_class),
        .pre_len   (pre_len),
        .up_len    (ramp_up_len),
        .dn_len    (ramp_dn_len),
        .mod_bad   (mod_bad),
        .sync_word (cfg_sync),
        .pre_n     (cfg_pre),
        .up_n      (cfg_up),
        .dn_n      (cfg_dn)
    );

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        rdy     = 1'b0;
        go_tail = 1'b0;
        if (s_q.ph == PH_IDLE) begin
            if (sym_en) begin
                s_d.sym = 1'b0;
                s_d.pa  = 1'b0;
            end
            if (start) begin
                if (mod_bad) begin
                    s_d.err = 1'b1;
                end else begin
                    s_d.sync  = cfg_sync;
                    s_d.pre_n = cfg_pre;
                    s_d.up_n  = cfg_up;
                    s_d.dn_n  = cfg_dn;
                    s_d.cnt   = '0;
                    s_d.last  = 1'b0;
                    s_d.ph    = (cfg_up != '0) ? PH_UP : PH_PRE;
                end
            end
        end else if (sym_en) begin
            s_d.pa  = 1'b1;
            s_d.cnt = s_q.cnt + ONE;
            case (s_q.ph)
                PH_UP: begin
                    s_d.sym = 1'b0;
                    if (s_q.cnt == s_q.up_n - ONE) begin
                        s_d.ph  = PH_PRE;
                        s_d.cnt = '0;
                    end
                end
                PH_PRE: begin
                    s_d.sym = ~s_q.cnt[0];
                    if (s_q.cnt == s_q.pre_n - ONE) begin
                        s_d.ph  = PH_SYNC;
                        s_d.cnt = '0;
                    end
                end
                PH_SYNC: begin
                    s_d.sym = s_q.sync[SYNC_TOP - s_q.cnt[SYNC_IW-1:0]];
                    if (s_q.cnt == SYNC_LAST) begin
                        rdy = 1'b1;
                        if (in_valid) begin
                            s_d.shreg = in_byte;
                            s_d.last  = in_last;
                            s_d.ph    = PH_DATA;
                            s_d.cnt   = '0;
                        end else begin
                            go_tail = 1'b1;
                        end
                    end
                end
                PH_DATA: begin
                    s_d.sym = s_q.shreg[BYTE_TOP - s_q.cnt[BIT_W-1:0]];
                    if (s_q.cnt[BIT_W-1:0] == BYTE_TOP) begin
                        if (!s_q.last) begin
                            rdy = 1'b1;
                            if (in_valid) begin
                                s_d.shreg = in_byte;
                                s_d.last  = in_last;
                                s_d.cnt   = '0;
                            end else begin
                                go_tail = 1'b1;
                            end
                        end else begin
                            go_tail = 1'b1;
                        end
                    end
                end
                PH_DN: begin
                    s_d.sym = 1'b0;
                    if (s_q.cnt == s_q.dn_n - ONE) begin
                        s_d.ph  = PH_IDLE;
                        s_d.cnt = '0;
                    end
                end
                default: s_d.ph = PH_IDLE;
            endcase
            if (go_tail) begin
                s_d.cnt = '0;
                s_d.ph  = (s_q.dn_n != '0) ? PH_DN : PH_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign in_ready = rdy;
    assign sym_out  = s_q.sym;
    assign pa_en    = s_q.pa;
    assign busy     = (s_q.ph != PH_IDLE);
    assign err      = s_q.err;
endmodule

// File: rtl/fsk_tx_framer_chk.sv
module fsk_tx_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic sym_en,
    input logic start,
    input logic in_ready,
    input logic sym_out,
    input logic pa_en,
    input logic busy,
    input logic err
);
    p_amp_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_en && busy) |=> pa_en);

    p_amp_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_en && !busy) |=> !pa_en);

    p_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (sym_en && busy));

    p_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && $past(start) && !$past(busy)));

    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !err);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_en |=> ($stable(sym_out) && $stable(pa_en)));
endmodule

bind fsk_tx_framer fsk_tx_framer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sym_en  (sym_en),
    .start   (start),
    .in_ready(in_ready),
    .sym_out (sym_out),
    .pa_en   (pa_en),
    .busy    (busy),
    .err     (err)
);

// File: tb/tb_fsk_tx_framer.sv
module tb_fsk_tx_framer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_en = 1'b0;
    logic       start = 1'b0;
    logic [7:0] chan_id = 8'h00;
    logic       sync_class = 1'b0;
    logic [7:0] pre_len = 8'd0;
    logic [5:0] ramp_up_len = 6'd0;
    logic [5:0] ramp_dn_len = 6'd0;
    logic [7:0] in_byte;
    logic       in_valid, in_last, in_ready, sym_out, pa_en, busy, err;

    int tests = 0, failed = 0, cyc = 0;
    logic [7:0] bytes [0:31];
    int  nb = 0, idx = 0;
    logic idx_clr = 1'b0;
    logic cap [0:1023];
    logic exp_s [0:1023];
    int  ncap = 0, exp_n = 0, hold_err = 0, err_seen = 0, div = 0;
    int  seg [0:5];
    logic prev_sym = 1'b0, prev_pa = 1'b0;

    // chan, class, pre, up, dn, nbytes
    localparam logic [33:0] VEC [0:5] = '{
        {8'h17, 1'b0, 8'd40,  6'd8,  6'd8,  5'd3},
        {8'h97, 1'b0, 8'd10,  6'd0,  6'd0,  5'd2},
        {8'h27, 1'b1, 8'd200, 6'd40, 6'd3,  5'd1},
        {8'hA7, 1'b1, 8'd0,   6'd1,  6'd32, 5'd4},
        {8'h1F, 1'b1, 8'd100, 6'd2,  6'd0,  5'd0},
        {8'h6A, 1'b0, 8'd60,  6'd5,  6'd5,  5'd2}
    };

    fsk_tx_framer dut (
        .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .start(start),
        .chan_id(chan_id), .sync_class(sync_class), .pre_len(pre_len),
        .ramp_up_len(ramp_up_len), .ramp_dn_len(ramp_dn_len),
        .in_byte(in_byte), .in_valid(in_valid), .in_last(in_last),
        .in_ready(in_ready), .sym_out(sym_out), .pa_en(pa_en),
        .busy(busy), .err(err)
    );

    always #4 clk = ~clk;

    assign in_valid = (idx < nb);
    assign in_last  = (idx == nb - 1);
    assign in_byte  = bytes[idx[4:0]];

    always @(posedge clk) begin
        if (idx_clr) idx <= 0;
        else if (in_ready && in_valid) idx <= idx + 1;
    end

    always @(negedge clk) begin
        if (sym_en) begin
            if (pa_en && ncap < 1024) begin
                cap[ncap] = sym_out;
                ncap++;
            end
        end else if (rst_n && (sym_out !== prev_sym || pa_en !== prev_pa)) begin
            hold_err++;
        end
        if (err) err_seen++;
        prev_sym = sym_out;
        prev_pa  = pa_en;
        div      = (div + 1) % 4;
        sym_en   = rst_n && (div == 0);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            failed++;
            tests++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic put(input logic b);
        exp_s[exp_n] = b;
        exp_n++;
    endtask

    task automatic build_exp(input logic [7:0] ch, input logic cls, input int pre,
                             input int up, input int dn, input int n);
        bit hi, fec;
        int pn, un, dn_c;
        logic [15:0] sw;
        hi   = (ch[5:4] == 2'd2);
        fec  = (ch[7:6] == 2'd2);
        pn   = hi ? ((pre < 48) ? 48 : (pre > 128) ? 128 : pre)
                  : ((pre < 32) ? 32 : (pre > 64) ? 64 : pre);
        un   = (up > 32) ? 32 : up;
        dn_c = (dn > 32) ? 32 : dn;
        sw   = cls ? (fec ? 16'h192F : 16'h0B67) : (fec ? 16'hF498 : 16'hE6D0);
        exp_n = 0;
        seg[0] = 0;
        for (int i = 0; i < un; i++) put(1'b0);
        seg[1] = exp_n;
        for (int i = 0; i < pn; i++) put((i % 2) == 0);
        seg[2] = exp_n;
        for (int i = 15; i >= 0; i--) put(sw[i]);
        seg[3] = exp_n;
        for (int k = 0; k < n; k++)
            for (int i = 7; i >= 0; i--) put(bytes[k][i]);
        seg[4] = exp_n;
        for (int i = 0; i < dn_c; i++) put(1'b0);
        seg[5] = exp_n;
    endtask

    task automatic cmp_seg(input int a, input int b, input string tag, input string what);
        int bad_at, act_v, exp_v;
        bad_at = -1; act_v = 0; exp_v = 0;
        for (int i = a; i < b; i++) begin
            if (bad_at < 0 && (i >= ncap || cap[i] !== exp_s[i])) begin
                bad_at = i;
                act_v  = (i < ncap) ? int'(cap[i]) : -1;
                exp_v  = int'(exp_s[i]);
            end
        end
        chk(bad_at < 0, tag, what, act_v, exp_v);
    endtask

    task automatic run_vec(input int v, input bit mid_start);
        logic [7:0] ch;
        logic cls;
        int pre, up, dn, n, guard;
        string ptag;
        {ch, cls} = VEC[v][33:25];
        pre = int'(VEC[v][24:17]);
        up  = int'(VEC[v][16:11]);
        dn  = int'(VEC[v][10:5]);
        n   = int'(VEC[v][4:0]);
        for (int k = 0; k < 32; k++) bytes[k] = 8'((v * 37 + k * 91 + 5) ^ (k << 3));
        build_exp(ch, cls, pre, up, dn, n);
        ptag = (ch[5:4] == 2'd2) ? "R2 R4" : "R2 R3";
        @(negedge clk);
        idx_clr = 1'b1;
        nb = n;
        chan_id = ch; sync_class = cls; pre_len = 8'(pre);
        ramp_up_len = 6'(up); ramp_dn_len = 6'(dn);
        @(negedge clk);
        idx_clr = 1'b0;
        ncap = 0; err_seen = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while ((busy || pa_en) && guard < 4000) begin
            @(negedge clk);
            guard++;
            if (mid_start && guard == 300) begin
                chan_id = 8'h37;
                start = 1'b1;
            end else if (mid_start && guard == 301) begin
                start = 1'b0;
                chan_id = 8'h05;
            end
        end
        chk(ncap == exp_n, "R1", $sformatf("vec %0d frame length", v), ncap, exp_n);
        cmp_seg(seg[0], seg[1], "R7", $sformatf("vec %0d ramp-up", v));
        cmp_seg(seg[1], seg[2], ptag, $sformatf("vec %0d preamble", v));
        cmp_seg(seg[2], seg[3], "R5", $sformatf("vec %0d sync word", v));
        cmp_seg(seg[3], seg[4], "R6", $sformatf("vec %0d data", v));
        cmp_seg(seg[4], seg[5], "R7", $sformatf("vec %0d ramp-down", v));
        chk(idx == n, "R6", $sformatf("vec %0d bytes taken", v), idx, n);
        if (mid_start) chk(err_seen == 0, "R9", "err during busy start", err_seen, 0);
    endtask

    task automatic refuse(input logic [7:0] ch);
        int busy_seen, pa_seen;
        @(negedge clk);
        chan_id = ch;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err == 1'b1 && busy == 1'b0, "R8", "err pulse after refused start",
            int'({err, busy}), 2);
        @(negedge clk);
        chk(err == 1'b0, "R8", "err lasts one cycle", int'(err), 0);
        busy_seen = 0; pa_seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (busy) busy_seen++;
            if (pa_en) pa_seen++;
        end
        chk(busy_seen == 0 && pa_seen == 0, "R8", "no frame after refusal",
            busy_seen + pa_seen, 0);
    endtask

    initial begin
        for (int k = 0; k < 32; k++) bytes[k] = 8'h00;
        repeat (3) @(negedge clk);
        chk({sym_out, pa_en, busy, err, in_ready} == 5'b0, "R10", "outputs in reset",
            int'({sym_out, pa_en, busy, err, in_ready}), 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk({sym_out, pa_en, busy, err, in_ready} == 5'b0, "R10", "outputs after reset",
            int'({sym_out, pa_en, busy, err, in_ready}), 0);

        for (int v = 0; v < 6; v++) run_vec(v, 1'b0);

        // directed corner cases
        run_vec(0, 1'b1);
        refuse(8'h07);
        refuse(8'h37);
        run_vec(3, 1'b0);
        chk(hold_err == 0, "R11", "outputs held between enables", hold_err, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule